// File: doc/BRIEF.md
# Multi-Mode ETU Timer Bank for a Smartcard Interface

This block holds three independent timers that count elementary time units (ETUs) for a contact smartcard interface. Software loads each timer with an ETU count and a 4-bit operating mode, then pulses its start control. The mode decides three things. It sets the count direction, down or up. It sets the start trigger: at once, on a start bit detected on the card I/O line, on a start bit fully received, or on a card activation request. It sets the reload rule: none, after each timeout, or on each detected start bit.

The ETU tick, the two start-bit event pulses and the activation request come from the surrounding reader logic as single-cycle pulses. Each timer reports its live counter value and a sticky timeout flag. Software clears the flag by writing one. A per-timer enable gates the flag onto an interrupt line. Every pin is a plain control or status level or pulse. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `sc_etu_timers`

## Requirements
- R1: A start pulse latches the mode and load value. In the next cycle the counter shows the load value, or zero for the up-count mode 8. Modes 0, 4, 8 and 15 begin counting straight away.
- R2: A running down-counter drops by one on each ETU tick. The tick that takes it from 1 (or from 0) to 0 sets the timeout flag in the same cycle. In mode 0 the timer then stops and holds 0. The counter never changes in a cycle that has no tick, no start and no detected start bit.
- R3: Modes 1, 5 and 7 wait for a detected start bit, and modes 2 and 6 wait for a fully received start bit. While a timer waits, it holds its load value, ignores ticks and the other start-bit event, and raises no flag. Counting starts with the first tick after the trigger cycle.
- R4: Mode 3 on timer 0 waits for the activation request, then counts down like mode 0. On timers 1 and 2, mode 3 acts as mode 0.
- R5: In modes 4, 5 and 6, a timeout sets the flag and reloads the load value in the same cycle. The timer keeps counting.
- R6: In modes 7 and 15, each detected start bit reloads the load value while the timer runs. A reload takes precedence over a tick in the same cycle. Mode 15 starts at once. Both modes stop at timeout.
- R7: Mode 8 counts up from 0 by one per tick. The tick on which the counter reaches the load value sets the flag, and the counter stops there.
- R8: The unlisted mode codes 9 to 14 behave as mode 0.
- R9: A stop pulse halts the timer at once. The counter keeps its value and no flag is raised. A stop wins over a start in the same cycle.
- R10: The timeout flag stays set until a clear pulse for that timer. A new timeout wins over a clear in the same cycle. The interrupt output is the flag ANDed with its enable.
- R11: The three timers run independently. Bit or field i of each per-timer port belongs to timer i, and count fields are CNT_W bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse per elapsed ETU |
| sb_detect | input | 1 | Pulse: start bit seen on the I/O line |
| sb_received | input | 1 | Pulse: start bit fully received |
| act_req | input | 1 | Pulse: card activation request |
| start_i | input | NUM_TMR | Per-timer start pulse |
| stop_i | input | NUM_TMR | Per-timer stop pulse |
| mode_i | input | NUM_TMR*4 | Per-timer mode code, timer i at bits [4i+3:4i] |
| load_i | input | NUM_TMR*CNT_W | Per-timer ETU load value |
| irq_en_i | input | NUM_TMR | Per-timer interrupt enable |
| flag_clr_i | input | NUM_TMR | Per-timer write-one-to-clear of the flag |
| tmo_flag_o | output | NUM_TMR | Sticky timeout flags |
| irq_o | output | NUM_TMR | Enabled timeout interrupts |
| cnt_o | output | NUM_TMR*CNT_W | Current counter values |

## Verification
The hardest case to reach is the interplay between a waiting or reloading timer and the I/O-line events. The bench must show that a timer armed for one event ignores ticks and the other event. It must also show that in mode 7 a start bit arriving mid-count restores the load value instead of letting the tick land. The stimulus reaches these cases with directed sequences that interleave tick pulses with single detect, receive and activation pulses. The counter is read back after every pulse, so a skipped wait, a wrong trigger source or a lost reload shows up as a wrong count.

// File: rtl/sc_etu_pkg.sv
package sc_etu_pkg;

  typedef enum logic [1:0] {
    SRC_NOW = 2'd0,
    SRC_DET = 2'd1,
    SRC_RCV = 2'd2,
    SRC_ACT = 2'd3
  } start_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } chan_st_e;

  typedef struct packed {
    logic       up;
    start_src_e src;
    logic       rl_tmo;
    logic       rl_det;
  } etu_cfg_t;

  localparam int MODE_W = 4;

endpackage

// File: rtl/sc_etu_dec.sv
module sc_etu_dec
  import sc_etu_pkg::*;
#(
  parameter bit ACT_OK = 1'b0
) (
  input  logic [MODE_W-1:0] mode_i,
  output etu_cfg_t          cfg_o
);

  always_comb begin
    cfg_o = '{up: 1'b0, src: SRC_NOW, rl_tmo: 1'b0, rl_det: 1'b0};
    case (mode_i)
      4'd1: cfg_o.src = SRC_DET;
      4'd2: cfg_o.src = SRC_RCV;
      4'd3: cfg_o.src = ACT_OK ? SRC_ACT : SRC_NOW;
      4'd4: cfg_o.rl_tmo = 1'b1;
      4'd5: begin
        cfg_o.src    = SRC_DET;
        cfg_o.rl_tmo = 1'b1;
      end
      4'd6: begin
        cfg_o.src    = SRC_RCV;
        cfg_o.rl_tmo = 1'b1;
      end
      4'd7: begin
        cfg_o.src    = SRC_DET;
        cfg_o.rl_det = 1'b1;
      end
      4'd8:  cfg_o.up = 1'b1;
      4'd15: cfg_o.rl_det = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_etu_chan.sv
module sc_etu_chan
  import sc_etu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit ACT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sb_det_i,
  input  logic              sb_rcv_i,
  input  logic              act_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  load_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [CNT_W-1:0]  cnt_o
);

  etu_cfg_t         new_cfg;
  etu_cfg_t         cfg_q, cfg_d;
  chan_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic             flag_q, flag_d;
  logic             tmo;
  logic             trig_hit;
  logic [CNT_W:0]   cnt_inc;
  logic             dn_end;
  logic             up_end;

  sc_etu_dec #(.ACT_OK(ACT_OK)) u_dec (
    .mode_i (mode_i),
    .cfg_o  (new_cfg)
  );

  always_comb begin
    case (cfg_q.src)
      SRC_DET: trig_hit = sb_det_i;
      SRC_RCV: trig_hit = sb_rcv_i;
      SRC_ACT: trig_hit = act_i;
      default: trig_hit = 1'b1;
    endcase
  end

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign dn_end  = (cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1});
  assign up_end  = (cnt_inc >= {1'b0, load_q});

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cfg_d  = cfg_q;
    load_d = load_q;
    tmo    = 1'b0;
    if (stop_i) begin
      st_d = ST_IDLE;
    end else if (start_i) begin
      cfg_d  = new_cfg;
      load_d = load_i;
      cnt_d  = new_cfg.up ? '0 : load_i;
      st_d   = (new_cfg.src == SRC_NOW) ? ST_RUN : ST_WAIT;
    end else begin
      case (st_q)
        ST_WAIT: begin
          if (trig_hit) st_d = ST_RUN;
        end
        ST_RUN: begin
          if (cfg_q.rl_det && sb_det_i) begin
            cnt_d = load_q;
          end else if (tick_i) begin
            if (cfg_q.up) begin
              if (up_end) begin
                tmo   = 1'b1;
                cnt_d = load_q;
                st_d  = ST_IDLE;
              end else begin
                cnt_d = cnt_inc[CNT_W-1:0];
              end
            end else if (dn_end) begin
              tmo = 1'b1;
              if (cfg_q.rl_tmo) begin
                cnt_d = load_q;
              end else begin
                cnt_d = '0;
                st_d  = ST_IDLE;
              end
            end else begin
              cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
            end
          end
        end
        default: ;
      endcase
    end
    flag_d = tmo ? 1'b1 : (clr_i ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      load_q <= '0;
      cfg_q  <= '{up: 1'b0, src: SRC_NOW, rl_tmo: 1'b0, rl_det: 1'b0};
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      load_q <= load_d;
      cfg_q  <= cfg_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/sc_etu_timers.sv
module sc_etu_timers
  import sc_etu_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       etu_tick,
  input  logic                       sb_detect,
  input  logic                       sb_received,
  input  logic                       act_req,
  input  logic [NUM_TMR-1:0]         start_i,
  input  logic [NUM_TMR-1:0]         stop_i,
  input  logic [NUM_TMR*MODE_W-1:0]  mode_i,
  input  logic [NUM_TMR*CNT_W-1:0]   load_i,
  input  logic [NUM_TMR-1:0]         irq_en_i,
  input  logic [NUM_TMR-1:0]         flag_clr_i,
  output logic [NUM_TMR-1:0]         tmo_flag_o,
  output logic [NUM_TMR-1:0]         irq_o,
  output logic [NUM_TMR*CNT_W-1:0]   cnt_o
);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    sc_etu_chan #(
      .CNT_W  (CNT_W),
      .ACT_OK (g == 0)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (etu_tick),
      .sb_det_i (sb_detect),
      .sb_rcv_i (sb_received),
      .act_i    (act_req),
      .start_i  (start_i[g]),
      .stop_i   (stop_i[g]),
      .mode_i   (mode_i[g*MODE_W +: MODE_W]),
      .load_i   (load_i[g*CNT_W +: CNT_W]),
      .clr_i    (flag_clr_i[g]),
      .flag_o   (tmo_flag_o[g]),
      .cnt_o    (cnt_o[g*CNT_W +: CNT_W])
    );
  end

  assign irq_o = tmo_flag_o & irq_en_i;

endmodule

// File: rtl/sc_etu_timers_chk.sv
module sc_etu_timers_chk #(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     etu_tick,
  input logic                     sb_detect,
  input logic [NUM_TMR-1:0]       start_i,
  input logic [NUM_TMR-1:0]       stop_i,
  input logic [NUM_TMR-1:0]       flag_clr_i,
  input logic [NUM_TMR-1:0]       tmo_flag_o,
  input logic [NUM_TMR-1:0]       irq_o,
  input logic [NUM_TMR*CNT_W-1:0] cnt_o
);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    assert_cnt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!etu_tick && !start_i[g] && !sb_detect) |=> $stable(cnt_o[g*CNT_W +: CNT_W]));

    assert_flag_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag_o[g]) |-> $past(etu_tick));

    assert_stop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i[g] |=> $stable(cnt_o[g*CNT_W +: CNT_W]));

    assert_stop_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i[g] && !tmo_flag_o[g]) |=> !tmo_flag_o[g]);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag_o[g] && !flag_clr_i[g]) |=> tmo_flag_o[g]);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> tmo_flag_o[g]);
  end

endmodule

bind sc_etu_timers sc_etu_timers_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .etu_tick   (etu_tick),
  .sb_detect  (sb_detect),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .flag_clr_i (flag_clr_i),
  .tmo_flag_o (tmo_flag_o),
  .irq_o      (irq_o),
  .cnt_o      (cnt_o)
);

// File: tb/sc_etu_timers_tb.sv
`timescale 1ns/1ps
module sc_etu_timers_tb;

  localparam int NT = 3;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic etu_tick = 1'b0, sb_detect = 1'b0, sb_received = 1'b0, act_req = 1'b0;
  logic [NT-1:0]    start_i = '0, stop_i = '0, irq_en_i = '0, flag_clr_i = '0;
  logic [NT*4-1:0]  mode_i = '0;
  logic [NT*CW-1:0] load_i = '0;
  logic [NT-1:0]    tmo_flag_o, irq_o;
  logic [NT*CW-1:0] cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_etu_timers #(.NUM_TMR(NT), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .sb_detect(sb_detect),
    .sb_received(sb_received), .act_req(act_req), .start_i(start_i),
    .stop_i(stop_i), .mode_i(mode_i), .load_i(load_i), .irq_en_i(irq_en_i),
    .flag_clr_i(flag_clr_i), .tmo_flag_o(tmo_flag_o), .irq_o(irq_o), .cnt_o(cnt_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cnt(input int i);
    return int'(cnt_o[i*CW +: CW]);
  endfunction

  task automatic tk(input int n);
    for (int k = 0; k < n; k++) begin
      etu_tick = 1'b1;
      @(negedge clk);
      etu_tick = 1'b0;
    end
  endtask

  task automatic go(input int i, input int md, input int ld);
    mode_i[i*4 +: 4] = md[3:0];
    load_i[i*CW +: CW] = ld[CW-1:0];
    start_i[i] = 1'b1;
    @(negedge clk);
    start_i[i] = 1'b0;
  endtask

  task automatic halt(input int i);
    stop_i[i] = 1'b1;
    @(negedge clk);
    stop_i[i] = 1'b0;
  endtask

  task automatic clean();
    stop_i = '1;
    flag_clr_i = '1;
    @(negedge clk);
    stop_i = '0;
    flag_clr_i = '0;
  endtask

  task automatic pulse_det();
    sb_detect = 1'b1; @(negedge clk); sb_detect = 1'b0;
  endtask

  task automatic pulse_rcv();
    sb_received = 1'b1; @(negedge clk); sb_received = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset flags", int'(tmo_flag_o), 0);
    chk("R1 reset cnt0", cnt(0), 0);
  endtask

  task automatic t_mode0();
    clean();
    irq_en_i[0] = 1'b1;
    go(0, 0, 3);
    chk("R1 mode0 loaded", cnt(0), 3);
    tk(1); chk("R2 dec 1", cnt(0), 2);
    tk(1); chk("R2 dec 2", cnt(0), 1);
    chk("R2 no early flag", int'(tmo_flag_o[0]), 0);
    tk(1); chk("R2 zero", cnt(0), 0);
    chk("R2 flag set", int'(tmo_flag_o[0]), 1);
    chk("R10 irq on", int'(irq_o[0]), 1);
    tk(2); chk("R2 stopped at 0", cnt(0), 0);
    flag_clr_i[0] = 1'b1; @(negedge clk); flag_clr_i[0] = 1'b0;
    chk("R10 w1c", int'(tmo_flag_o[0]), 0);
    irq_en_i[0] = 1'b0;
  endtask

  task automatic t_wait_det();
    clean();
    go(1, 1, 4);
    tk(3); chk("R3 wait holds", cnt(1), 4);
    pulse_rcv(); tk(1); chk("R3 rcv ignored", cnt(1), 4);
    chk("R3 no flag wait", int'(tmo_flag_o[1]), 0);
    pulse_det(); chk("R3 trig cycle", cnt(1), 4);
    tk(1); chk("R3 counts after det", cnt(1), 3);
  endtask

  task automatic t_wait_rcv();
    clean();
    go(2, 2, 2);
    pulse_det(); tk(1); chk("R3 det ignored mode2", cnt(2), 2);
    pulse_rcv(); tk(1); chk("R3 counts after rcv", cnt(2), 1);
  endtask

  task automatic t_act();
    clean();
    go(0, 3, 2);
    tk(1); chk("R4 t0 waits act", cnt(0), 2);
    act_req = 1'b1; @(negedge clk); act_req = 1'b0;
    tk(2); chk("R4 t0 zero", cnt(0), 0);
    chk("R4 t0 flag", int'(tmo_flag_o[0]), 1);
    go(1, 3, 2);
    tk(1); chk("R4 t1 mode3 as mode0", cnt(1), 1);
  endtask

  task automatic t_reload();
    clean();
    go(0, 4, 2);
    tk(2); chk("R5 reloaded", cnt(0), 2);
    chk("R5 flag", int'(tmo_flag_o[0]), 1);
    tk(1); chk("R5 keeps running", cnt(0), 1);
    go(1, 5, 1);
    tk(1); chk("R5 mode5 waits", cnt(1), 1);
    pulse_det(); tk(2);
    chk("R5 mode5 reload", cnt(1), 1);
    chk("R5 mode5 flag", int'(tmo_flag_o[1]), 1);
  endtask

  task automatic t_det_reload();
    clean();
    go(1, 7, 3);
    tk(1); chk("R6 mode7 waits", cnt(1), 3);
    pulse_det(); tk(1); chk("R6 mode7 runs", cnt(1), 2);
    etu_tick = 1'b1; sb_detect = 1'b1; @(negedge clk);
    etu_tick = 1'b0; sb_detect = 1'b0;
    chk("R6 det beats tick", cnt(1), 3);
    tk(3); chk("R6 mode7 timeout", int'(tmo_flag_o[1]), 1);
    tk(1); chk("R6 mode7 stopped", cnt(1), 0);
    go(2, 15, 3);
    tk(1); chk("R6 mode15 immediate", cnt(2), 2);
    pulse_det(); chk("R6 mode15 reload", cnt(2), 3);
  endtask

  task automatic t_up();
    clean();
    go(0, 8, 3);
    chk("R7 starts at 0", cnt(0), 0);
    tk(2); chk("R7 up 2", cnt(0), 2);
    chk("R7 no early flag", int'(tmo_flag_o[0]), 0);
    tk(1); chk("R7 reached", cnt(0), 3);
    chk("R7 flag", int'(tmo_flag_o[0]), 1);
    tk(1); chk("R7 holds", cnt(0), 3);
  endtask

  task automatic t_unlisted();
    clean();
    go(1, 10, 2);
    tk(2); chk("R8 code10 zero", cnt(1), 0);
    chk("R8 code10 flag", int'(tmo_flag_o[1]), 1);
    go(2, 13, 1);
    pulse_det(); chk("R8 code13 no reload", cnt(2), 1);
    tk(1); chk("R8 code13 flag", int'(tmo_flag_o[2]), 1);
  endtask

  task automatic t_stop();
    clean();
    go(2, 0, 5);
    tk(1); halt(2);
    chk("R9 holds at stop", cnt(2), 4);
    tk(5); chk("R9 no count", cnt(2), 4);
    chk("R9 no flag", int'(tmo_flag_o[2]), 0);
    load_i[2*CW +: CW] = 16'd9;
    start_i[2] = 1'b1; stop_i[2] = 1'b1; @(negedge clk);
    start_i[2] = 1'b0; stop_i[2] = 1'b0;
    chk("R9 stop beats start", cnt(2), 4);
    tk(1); chk("R9 still idle", cnt(2), 4);
  endtask

  task automatic t_flag();
    clean();
    go(0, 0, 1);
    etu_tick = 1'b1; flag_clr_i[0] = 1'b1; @(negedge clk);
    etu_tick = 1'b0; flag_clr_i[0] = 1'b0;
    chk("R10 set beats clear", int'(tmo_flag_o[0]), 1);
    chk("R10 irq masked", int'(irq_o[0]), 0);
    irq_en_i[0] = 1'b1; #1;
    chk("R10 irq enabled", int'(irq_o[0]), 1);
    irq_en_i[0] = 1'b0;
  endtask

  task automatic t_indep();
    clean();
    go(0, 0, 5);
    go(1, 0, 2);
    tk(2);
    chk("R11 t0 own count", cnt(0), 3);
    chk("R11 t1 own count", cnt(1), 0);
    chk("R11 flags", int'(tmo_flag_o), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_wait_det();
    t_wait_rcv();
    t_act();
    t_reload();
    t_det_reload();
    t_up();
    t_unlisted();
    t_stop();
    t_flag();
    t_indep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule